// File: doc/BRIEF.md
# Port interrupt-on-change detector

This block watches the upper four pins of an 8-bit input port and raises an interrupt request when any of them moves away from a stored reference. The pins first pass through a two-flop synchronizer. On every instruction cycle, marked by a one-cycle phase strobe, the synchronized pins are compared with a reference latch. Any difference sets a sticky change flag.

The reference latch is loaded only when the CPU reads the port. A difference therefore keeps counting until software reads the port. The flag is separate from the reference latch and must be cleared by its own software clear. The usual service routine reads the port and then clears the flag.

The interrupt request needs the flag, a port-change enable and a global enable all at 1. While the core sleeps, the reference latch holds its value and the compare keeps running. A wake output then reports a set flag whenever the port-change enable is 1, whatever the state of the global enable.

Top module: `port_change_irq`

## Requirements
- R1: After reset the flag and both enables are 0, and irq_o and wake_o are 0. The reference latch holds the pin values present during reset, so pins that stay unchanged after reset never set the flag.
- R2: When phase_i is 1 on every cycle, a pin change driven before clock edge k makes irq_o go high after edge k+2, and not earlier. Two edges are spent in the synchronizer and one in the flag register.
- R3: The compare acts only on cycles where phase_i is 1. A difference present while phase_i stays 0 leaves the flag at 0. The first cycle with phase_i at 1 sets the flag.
- R4: A cycle with port_rd_i at 1 loads the reference latch with the synchronized pins. After that read and a clear, the same pin values do not set the flag again.
- R5: Once set, the flag stays at 1 after the pins return to the reference value and after a port read.
- R6: flag_clr_i at 1 clears the flag at the next edge. If a difference is being detected in that same cycle, the flag stays at 1, because setting wins over clearing.
- R7: irq_o is 1 exactly when the flag, the port-change enable and the global enable are all 1. The enables are loaded from cfg_chg_en_i and cfg_glb_en_i on a cycle with cfg_wr_i at 1.
- R8: While sleep_i is 1 the compare stays active. wake_o is 1 exactly when sleep_i, the flag and the port-change enable are all 1, whatever the value of the global enable.
- R9: A change on any single pin, or on any combination of pins, sets the flag. Every ordered pair of reference value and new pin value, from 0 to 15, is covered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 4 | Upper nibble of the input port (bits 4 to 7), asynchronous |
| phase_i | input | 1 | One-cycle instruction-phase strobe that enables the compare |
| port_rd_i | input | 1 | CPU port read; loads the reference latch |
| flag_clr_i | input | 1 | Software clear of the change flag |
| cfg_wr_i | input | 1 | Loads both enable bits |
| cfg_chg_en_i | input | 1 | Port-change enable value to load |
| cfg_glb_en_i | input | 1 | Global interrupt enable value to load |
| sleep_i | input | 1 | Core is in sleep mode |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request while sleeping |

## Verification
A pin change reaches irq_o or wake_o three edges after it is driven: two synchronizer edges and one flag edge. The bench checks the output after two edges, where it must still be low, and again after three edges, where it must be high. A clear, a read or an enable write takes effect at the one edge on which it is driven. irq_o and wake_o are combinational from the registers and from sleep_i, so a change of sleep_i is checked in the same cycle. All inputs are driven just after the falling edge and all outputs are sampled at the next falling edge, so each check falls on a whole number of rising edges after its stimulus.

// File: rtl/pcint_pkg.sv
// Shared types for the port interrupt-on-change detector.
package pcint_pkg;
    // Enable bits held by the flag stage
    typedef struct packed {
        logic chg_en;   // port-change interrupt enable
        logic glb_en;   // global interrupt enable
    } pcint_en_t;
endpackage

// File: rtl/pcint_sync.sv
// Multi-stage synchronizer for asynchronous port pins.
// Assumes each pin is a slow level input; no reset, so the chain keeps
// sampling during reset and the reference latch can load real pin values.
module pcint_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift the pin vector through the synchronizer stages
    always_ff @(posedge clk) begin
        stg[0] <= d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcint_ref.sv
// Reference latch and comparator.
// The latch loads the synchronized pins in reset and on a port read only.
// A mismatch is reported on phase cycles; a read cycle reports none,
// because the latch takes the current value in that very cycle.
module pcint_ref #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] samp_i,
    input  logic         phase_i,
    input  logic         rd_i,
    output logic         mismatch_o
);
    logic [W-1:0] ref_q;
    logic [W-1:0] diff;

    // Load the reference with the synchronized pins in reset and on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= samp_i;
        end else if (rd_i) begin
            ref_q <= samp_i;
        end
    end

    // Per-pin difference, reduced to one strobed mismatch
    always_comb begin
        diff       = samp_i ^ ref_q;
        mismatch_o = phase_i && !rd_i && (|diff);
    end
endmodule

// File: rtl/pcint_flag.sv
// Sticky change flag, enable register and request outputs.
// Assumes set and clear are single-cycle strobes; set has priority.
module pcint_flag
    import pcint_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      set_i,
    input  logic      clr_i,
    input  logic      cfg_wr_i,
    input  pcint_en_t cfg_i,
    input  logic      sleep_i,
    output logic      flag_o,
    output pcint_en_t en_o,
    output logic      irq_o,
    output logic      wake_o
);
    // Sticky flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // Enable register written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (cfg_wr_i) begin
            en_o <= cfg_i;
        end
    end

    // Request outputs
    always_comb begin
        irq_o  = flag_o && en_o.chg_en && en_o.glb_en;
        wake_o = flag_o && en_o.chg_en && sleep_i;
    end
endmodule

// File: rtl/port_change_irq.sv
// Port interrupt-on-change detector, top level.
// Synchronizes the upper port nibble, compares it on phase strobes with a
// reference loaded by port reads, and raises irq/wake from a sticky flag.
module port_change_irq
    import pcint_pkg::*;
#(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    input  logic         phase_i,
    input  logic         port_rd_i,
    input  logic         flag_clr_i,
    input  logic         cfg_wr_i,
    input  logic         cfg_chg_en_i,
    input  logic         cfg_glb_en_i,
    input  logic         sleep_i,
    output logic         irq_o,
    output logic         wake_o
);
    logic [W-1:0] samp;
    logic         mismatch;
    logic         flag_q;
    pcint_en_t    en_q;
    pcint_en_t    cfg_in;

    // Pack the enable write data
    always_comb begin
        cfg_in.chg_en = cfg_chg_en_i;
        cfg_in.glb_en = cfg_glb_en_i;
    end

    pcint_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (pins_i),
        .q_o (samp)
    );

    pcint_ref #(.W(W)) u_ref (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_i     (samp),
        .phase_i    (phase_i),
        .rd_i       (port_rd_i),
        .mismatch_o (mismatch)
    );

    pcint_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (mismatch),
        .clr_i    (flag_clr_i),
        .cfg_wr_i (cfg_wr_i),
        .cfg_i    (cfg_in),
        .sleep_i  (sleep_i),
        .flag_o   (flag_q),
        .en_o     (en_q),
        .irq_o    (irq_o),
        .wake_o   (wake_o)
    );
endmodule

// File: rtl/pcint_chk.sv
// Assertion checker for port_change_irq, attached by bind.
module pcint_chk
    import pcint_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      phase_i,
    input logic      flag_clr_i,
    input logic      sleep_i,
    input logic      irq_o,
    input logic      wake_o,
    input logic      mismatch,
    input logic      flag,
    input pcint_en_t en
);
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag);

    p_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_i && !flag) |=> !flag);

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr_i) |=> flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !mismatch) |=> !flag);

    p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag && en.glb_en));

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (sleep_i && en.chg_en));
endmodule

bind port_change_irq pcint_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase_i),
    .flag_clr_i (flag_clr_i),
    .sleep_i    (sleep_i),
    .irq_o      (irq_o),
    .wake_o     (wake_o),
    .mismatch   (mismatch),
    .flag       (flag_q),
    .en         (en_q)
);

// File: tb/tb_port_change_irq.sv
`timescale 1ns/1ps
module tb_port_change_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'hA;
    logic       phase = 1'b1;
    logic       port_rd = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_c = 1'b0;
    logic       cfg_g = 1'b0;
    logic       sleep = 1'b0;
    logic       irq;
    logic       wake;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    port_change_irq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (pins),
        .phase_i      (phase),
        .port_rd_i    (port_rd),
        .flag_clr_i   (flag_clr),
        .cfg_wr_i     (cfg_wr),
        .cfg_chg_en_i (cfg_c),
        .cfg_glb_en_i (cfg_g),
        .sleep_i      (sleep),
        .irq_o        (irq),
        .wake_o       (wake)
    );

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic pulse_rd();
        port_rd = 1'b1; cyc(1); port_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    task automatic set_cfg(input logic c, input logic g);
        cfg_c = c; cfg_g = g; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset state and reference taken from the pins during reset
        cyc(4);
        rst_n = 1'b1;
        chk(irq, 1'b0, "R1 irq after reset");
        chk(wake, 1'b0, "R1 wake after reset");
        cyc(4);
        set_cfg(1'b1, 1'b1);
        cyc(1);
        chk(irq, 1'b0, "R1 no flag with unchanged pins");

        // R3: no compare without the phase strobe
        phase = 1'b0;
        pins = 4'h5;
        cyc(6);
        chk(irq, 1'b0, "R3 no set without phase");
        phase = 1'b1; cyc(1); phase = 1'b0;
        chk(irq, 1'b1, "R3 set on phase cycle");
        phase = 1'b1;

        // R5: flag is sticky
        pins = 4'hA;
        cyc(4);
        chk(irq, 1'b1, "R5 flag held after pins return");
        pulse_rd();
        chk(irq, 1'b1, "R5 read does not clear");
        pulse_clr();
        chk(irq, 1'b0, "R6 clear");

        // R6: set wins over a simultaneous clear
        pins = 4'h3;
        cyc(3);
        chk(irq, 1'b1, "R6 flag set before clear");
        pulse_clr();
        chk(irq, 1'b1, "R6 set wins over clear");
        pulse_rd();
        pulse_clr();
        chk(irq, 1'b0, "R4 clear after read");
        cyc(4);
        chk(irq, 1'b0, "R4 no set after reference reload");

        // R7: irq needs both enables
        pins = 4'hC;
        cyc(3);
        for (int e = 0; e < 4; e++) begin
            set_cfg(e[1], e[0]);
            chk(irq, e[1] & e[0], "R7 enable gating");
        end
        set_cfg(1'b1, 1'b1);

        // R8: sleep compare and wake without global enable
        pulse_rd();
        pulse_clr();
        set_cfg(1'b1, 1'b0);
        sleep = 1'b1;
        chk(wake, 1'b0, "R8 wake idle");
        pins = 4'h0;
        cyc(2);
        chk(wake, 1'b0, "R8 wake latency");
        cyc(1);
        chk(wake, 1'b1, "R8 wake in sleep");
        chk(irq, 1'b0, "R7 no irq without global enable");
        sleep = 1'b0;
        #1;
        chk(wake, 1'b0, "R8 wake only in sleep");
        set_cfg(1'b0, 1'b0);
        sleep = 1'b1;
        #1;
        chk(wake, 1'b0, "R8 wake needs change enable");
        sleep = 1'b0;
        set_cfg(1'b1, 1'b1);
        pulse_rd();
        pulse_clr();

        // R2 / R9: every ordered pair of reference and new pin value
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 16; n++) begin
                pins = o[3:0];
                cyc(3);
                pulse_rd();
                pulse_clr();
                chk(irq, 1'b0, "R4 idle after read and clear");
                pins = n[3:0];
                cyc(2);
                chk(irq, 1'b0, "R2 not before third edge");
                cyc(1);
                chk(irq, (o != n), "R9 change per pin pattern");
            end
        end

        finish_run();
    end
endmodule